// File: doc/BRIEF.md
# Paper Supply Page Counter

This block tracks how many pages of paper remain in a printer's supply. Software writes a starting page count as one whole word. Each time the print path reports a finished page, the count drops by one. When the count reaches zero, the block sets a sticky page-count-zero status bit and raises an interrupt request for a single cycle. Interrupt vectoring is handled elsewhere.

A diagnostic path lets software step the counter upward. This works only while the controller's mode field selects test mode and its test-select field selects the counter test. In that configuration, every write of 1 to the go-error control bit adds one to the count. This exercises the counter without feeding any paper.

Top module: `pgcnt_top`

## Requirements
- R1: After synchronous reset (rstN low at a clock edge), pageCount is 0, zeroFlag is 0 and irqReq is 0.
- R2: A cycle with loadEn high makes pageCount equal loadData after that clock edge. A load takes priority over an increment, a decrement and a clear in the same cycle.
- R3: When pageDone is high, the count is nonzero, and neither a load nor a test increment occurs in that cycle, pageCount decreases by exactly one.
- R4: When pageDone is high while pageCount is 0, the count stays at 0 and no interrupt is raised.
- R5: A decrement from 1 to 0 sets zeroFlag and drives irqReq high for exactly the following cycle. irqReq is never high at any other time.
- R6: Once set, zeroFlag stays set until one of two events clears it: a load with nonzero loadData, or a cycle with zeroClr high. A load of zero leaves zeroFlag unchanged. If zeroClr arrives in the same cycle as a decrement to zero, the flag is still set.
- R7: When modeSel equals 3'd2, testSel equals 3'd6, goErrWr is high and goErrBit is 1, pageCount increases by one and wraps from 12'hFFF to 0. This increment takes priority over pageDone in the same cycle and never sets zeroFlag.
- R8: A goErrWr with goErrBit at 0 has no effect on pageCount. So does a goErrWr while modeSel is not 3'd2 or testSel is not 3'd6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadEn | input | 1 | Word write strobe for the count |
| loadData | input | 12 | Count value to load |
| pageDone | input | 1 | One page finished printing |
| modeSel | input | 3 | Controller mode field (2 = test) |
| testSel | input | 3 | Test-select field (6 = counter test) |
| goErrWr | input | 1 | Write strobe for the go-error control bit |
| goErrBit | input | 1 | Value written to the go-error bit |
| zeroClr | input | 1 | Write-one-to-clear strobe for the zero flag |
| pageCount | output | 12 | Current count |
| zeroFlag | output | 1 | Page-count-zero status |
| irqReq | output | 1 | One-cycle interrupt request |

## Verification
Every update takes effect at the next clock edge. As a result, a wrong count, a lost priority or a wrong flag shows on pageCount or zeroFlag one cycle after the stimulus that caused it. The bench compares all three outputs against its own model on every cycle. A count that wraps wrongly or that moves below zero shows up the first time the random stream revisits that boundary. A missed or doubled interrupt shows as an irqReq value that differs from the model in the cycle right after the decrement to zero.

// File: rtl/pgcnt_pkg.sv
package pgcnt_pkg;
  parameter int CNT_W = 12;
  parameter logic [2:0] MODE_TEST = 3'd2;
  parameter logic [2:0] TSEL_PCNT = 3'd6;

  typedef struct packed {
    logic doLoad;
    logic doInc;
    logic doDec;
    logic setZero;
    logic clrZero;
  } pgcntCmd_t;
endpackage

// File: rtl/pgcnt_ctrl.sv
module pgcnt_ctrl
  import pgcnt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         loadEn,
  input  logic [W-1:0] loadData,
  input  logic         pageDone,
  input  logic [2:0]   modeSel,
  input  logic [2:0]   testSel,
  input  logic         goErrWr,
  input  logic         goErrBit,
  input  logic         zeroClr,
  input  logic [W-1:0] curCount,
  output pgcntCmd_t    cmd
);
  localparam logic [W-1:0] ONE = W'(1);

  logic testCfg;
  logic isZero;

  always_comb begin
    testCfg = (modeSel == MODE_TEST) && (testSel == TSEL_PCNT);
    isZero  = (curCount == '0);
    cmd = '0;
    if (loadEn) begin
      cmd.doLoad  = 1'b1;
      cmd.clrZero = (loadData != '0);
    end else begin
      if (testCfg && goErrWr && goErrBit) begin
        cmd.doInc = 1'b1;
      end else if (pageDone && !isZero) begin
        cmd.doDec   = 1'b1;
        cmd.setZero = (curCount == ONE);
      end
      if (zeroClr && !cmd.setZero) cmd.clrZero = 1'b1;
    end
  end
endmodule

// File: rtl/pgcnt_dp.sv
module pgcnt_dp
  import pgcnt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  pgcntCmd_t    cmd,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] count,
  output logic         zeroFlag,
  output logic         irqReq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      zeroFlag <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      if (cmd.doLoad)     count <= loadData;
      else if (cmd.doInc) count <= count + W'(1);
      else if (cmd.doDec) count <= count - W'(1);

      if (cmd.setZero)      zeroFlag <= 1'b1;
      else if (cmd.clrZero) zeroFlag <= 1'b0;

      irqReq <= cmd.setZero;
    end
  end
endmodule

// File: rtl/pgcnt_top.sv
module pgcnt_top
  import pgcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadData,
  input  logic             pageDone,
  input  logic [2:0]       modeSel,
  input  logic [2:0]       testSel,
  input  logic             goErrWr,
  input  logic             goErrBit,
  input  logic             zeroClr,
  output logic [CNT_W-1:0] pageCount,
  output logic             zeroFlag,
  output logic             irqReq
);
  pgcntCmd_t cmd;

  pgcnt_ctrl #(.W(CNT_W)) ctrl_i (
    .loadEn(loadEn), .loadData(loadData), .pageDone(pageDone),
    .modeSel(modeSel), .testSel(testSel), .goErrWr(goErrWr),
    .goErrBit(goErrBit), .zeroClr(zeroClr), .curCount(pageCount),
    .cmd(cmd)
  );

  pgcnt_dp #(.W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadData(loadData),
    .count(pageCount), .zeroFlag(zeroFlag), .irqReq(irqReq)
  );
endmodule

// File: rtl/pgcnt_chk.sv
module pgcnt_chk
  import pgcnt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [CNT_W-1:0] loadData,
  input logic             pageDone,
  input logic [2:0]       modeSel,
  input logic [2:0]       testSel,
  input logic             goErrWr,
  input logic             goErrBit,
  input logic             zeroClr,
  input logic [CNT_W-1:0] pageCount,
  input logic             zeroFlag,
  input logic             irqReq
);
  logic incReq;
  assign incReq = modeSel == 3'd2 && testSel == 3'd6 && goErrWr && goErrBit;

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> pageCount == $past(loadData));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !loadEn && !incReq && pageCount != '0)
      |=> pageCount == $past(pageCount) - CNT_W'(1));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !loadEn && !incReq && pageCount == '0)
      |=> (pageCount == '0 && !irqReq));

  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> zeroFlag);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

  // R7
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incReq && !loadEn) |=> pageCount == $past(pageCount) + CNT_W'(1));

  // R8
  goerr_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goErrWr && !incReq && !loadEn && !pageDone) |=> $stable(pageCount));
endmodule

bind pgcnt_top pgcnt_chk chk_i (.*);

// File: tb/pgcnt_tb.sv
module pgcnt_top_tb_top;
  import pgcnt_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [11:0] loadData = '0;
  logic pageDone = 1'b0;
  logic [2:0] modeSel = '0;
  logic [2:0] testSel = '0;
  logic goErrWr = 1'b0;
  logic goErrBit = 1'b0;
  logic zeroClr = 1'b0;
  logic [11:0] pageCount;
  logic zeroFlag;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  logic [11:0] mCnt = '0;
  logic mFlag = 1'b0;
  logic mIrq = 1'b0;

  always #2 clk = ~clk;

  pgcnt_top dut_i (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic incHit(input logic [2:0] m, input logic [2:0] t,
                                  input logic w, input logic b);
    return m == 3'd2 && t == 3'd6 && w && b;
  endfunction

  function automatic string tagOf();
    if (loadEn) return "R2";
    if (incHit(modeSel, testSel, goErrWr, goErrBit)) return "R7";
    if (goErrWr) return "R8";
    if (pageDone && mCnt == 0) return "R4";
    if (pageDone && mCnt == 1) return "R5";
    if (pageDone) return "R3";
    return "R6";
  endfunction

  task automatic modelStep();
    logic setZ;
    setZ = 1'b0;
    if (loadEn) begin
      mCnt = loadData;
      if (loadData != 0) mFlag = 1'b0;
    end else begin
      if (incHit(modeSel, testSel, goErrWr, goErrBit)) mCnt = mCnt + 12'd1;
      else if (pageDone && mCnt != 0) begin
        setZ = (mCnt == 12'd1);
        mCnt = mCnt - 12'd1;
      end
      if (setZ) mFlag = 1'b1;
      else if (zeroClr) mFlag = 1'b0;
    end
    mIrq = setZ;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (pageCount !== mCnt || zeroFlag !== mFlag || irqReq !== mIrq) begin
      errors++;
      $display("FAIL %s: cnt=%h flag=%b irq=%b expected cnt=%h flag=%b irq=%b",
               tag, pageCount, zeroFlag, irqReq, mCnt, mFlag, mIrq);
    end
  endtask

  task automatic step(input string forced);
    string tag;
    tag = (forced != "") ? forced : tagOf();
    modelStep();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    loadEn = 0; pageDone = 0; goErrWr = 0; goErrBit = 0; zeroClr = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;

    // directed: load 2, decrement to zero
    loadEn = 1; loadData = 12'd2; step("R2");
    pageDone = 1; step("R3");
    pageDone = 1; step("R5");
    step("R5");
    pageDone = 1; step("R4");
    // load zero keeps flag, clear drops it
    loadEn = 1; loadData = 12'd0; step("R6");
    zeroClr = 1; step("R6");
    // set beats clear
    loadEn = 1; loadData = 12'd1; step("R2");
    pageDone = 1; zeroClr = 1; step("R6");
    // nonzero load clears flag; load beats increment
    loadEn = 1; loadData = 12'hFFF; modeSel = 3'd2; testSel = 3'd6;
    goErrWr = 1; goErrBit = 1; step("R2");
    // wrap via test increment, beats pageDone
    goErrWr = 1; goErrBit = 1; pageDone = 1; step("R7");
    goErrWr = 1; goErrBit = 0; step("R8");
    testSel = 3'd5; goErrWr = 1; goErrBit = 1; step("R8");
    modeSel = 3'd1; testSel = 3'd6; goErrWr = 1; goErrBit = 1; step("R8");

    for (int i = 0; i < 3000; i++) begin
      loadEn   = ($urandom % 16) == 0;
      loadData = ($urandom % 4 == 0) ? 12'($urandom % 4) : 12'($urandom);
      pageDone = ($urandom % 2) == 0;
      if ($urandom % 2 == 0) begin
        modeSel = 3'd2; testSel = 3'd6;
      end else begin
        modeSel = 3'($urandom); testSel = 3'($urandom);
      end
      goErrWr  = ($urandom % 4) == 0;
      goErrBit = ($urandom % 2) == 0;
      zeroClr  = ($urandom % 8) == 0;
      step("");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule